// File: doc/BRIEF.md
# Dual Comparator Control and Interrupt Logic

This block is the digital side of a pair of analog comparators. For each channel it holds an enable bit, two input-select bits that steer the analog multiplexers, and a gain code for an optional front-end amplifier. The compare result arrives from the analog macro as a raw 1-bit signal. The block synchronises that signal, presents it as the visible output bit and records every change of that bit in a sticky flag. The flag, gated by a per-channel interrupt enable, becomes an interrupt request.

Each channel runs a three-state machine. CH_OFF is the disabled state, in which the output is forced high. CH_SETTLE covers the settling window after an enable. CH_READY means the output can be trusted. The transitions are: OFF to SETTLE when the enable bit is set (the settle counter starts at zero); SETTLE to READY when the counter reaches its last value; SETTLE to OFF and READY to OFF when the enable bit is cleared. A disabled channel drives its output high, so turning off a channel whose output was low produces a low-to-high edge, and that edge sets the flag like any other change.

A small register port writes control bits, reads control and status, and clears flags.

Top module: `cmp_ctrl_top`

## Requirements
- R1: With a channel enabled, its output bit follows the raw compare input (1 means the positive input exceeds the negative one) through a two-flop synchroniser. A raw change set up before clock edge n appears at the output after edge n+2.
- R2: Control register bit 1 drives that channel's positive-input select (0 = first source, 1 = second source). Bit 2 drives its negative-input select (0 = pin, 1 = internal reference). Bit 0 drives its analog enable.
- R3: Any change of a channel's output bit sets that channel's flag. The flag stays set after the output returns to its earlier value.
- R4: A disabled channel outputs 1 and ignores its raw input. Disabling a channel whose output was 0 sets its flag on the edge after the control write.
- R5: A flag is cleared only by writing 1 to bit c of the status register (address NUM_CH) for channel c. Writing 0 to that bit, or writing any control register, leaves the flag unchanged.
- R6: If a clear and an output change fall on the same clock edge, the flag stays set.
- R7: The interrupt request equals flag AND interrupt enable (control bit 3). Setting the enable while a stale flag is set raises the request on the edge of the write.
- R8: The settled status bit is 0 while the channel is off. It rises SETTLE_CYCLES+1 edges after the edge of the enabling write. Disabling clears it, and re-enabling restarts the count.
- R9: Control bits 5:4 hold the gain code: 00 = 2x, 01 = 4x, 10 = 8x, 11 = 16x. The code appears on gain_sel[2c+1:2c] and reads back at address c.
- R10: Reset leaves every channel disabled, with output 1, flag 0, interrupt enable 0 and gain code 00. The status register then reads flags in bits [NUM_CH-1:0], outputs in bits [2*NUM_CH-1:NUM_CH] and settled bits in bits [3*NUM_CH-1:2*NUM_CH]. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 2 | Register address: channel control at c, status at NUM_CH |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 6 | Read data for reg_addr |
| cmp_raw | input | 2 | Raw compare result per channel from the analog macro |
| ana_en | output | 2 | Analog enable per channel |
| pos_sel | output | 2 | Positive-input select per channel |
| neg_sel | output | 2 | Negative-input select per channel (1 = reference) |
| gain_sel | output | 4 | Two-bit gain code per channel |
| cmp_out | output | 2 | Visible comparator output bit |
| cmp_flag | output | 2 | Sticky change flag |
| cmp_irq | output | 2 | Interrupt request |
| cmp_settled | output | 2 | Output valid after the settle window |

## Verification
The assertions assume that cmp_raw may change at any time relative to the clock but only reaches the flag logic through the synchroniser. They also assume that register writes last one cycle and are driven while reset is released. The stimulus changes cmp_raw and the write signals only on falling edges. It holds each raw level for at least three cycles, so every change propagates to the output before the next one. The one exception is the same-edge scenario for R6, where a clear is deliberately placed on the edge at which the output changes.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    typedef enum logic [1:0] {
        CH_OFF    = 2'd0,
        CH_SETTLE = 2'd1,
        CH_READY  = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        GAIN_X2  = 2'd0,
        GAIN_X4  = 2'd1,
        GAIN_X8  = 2'd2,
        GAIN_X16 = 2'd3
    } gain_e;

    typedef struct packed {
        gain_e gain;
        logic  ie;
        logic  neg;
        logic  pos;
        logic  en;
    } ctrl_t;

    localparam int CTRL_W = 6;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cmp_chan.sv
module cmp_chan
    import cmp_pkg::*;
#(
    parameter int SETTLE_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic en_i,
    input  logic clr_i,
    output logic out_o,
    output logic flag_o,
    output logic settled_o
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

    ch_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             sync_val, out_q, flag_q, out_d, chg;

    cmp_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_i),
        .q_o  (sync_val)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_OFF:    if (en_i) st_d = CH_SETTLE;
            CH_SETTLE: if (!en_i) st_d = CH_OFF;
                       else if (cnt_q == CNT_LAST) st_d = CH_READY;
            CH_READY:  if (!en_i) st_d = CH_OFF;
            default:   st_d = CH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_d;
    end

    assign out_d = en_i ? sync_val : 1'b1;
    assign chg   = (out_d != out_q);

    // output / datapath register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= 1'b1;
            flag_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            out_q  <= out_d;
            flag_q <= chg | (flag_q & ~clr_i);
            if (st_q == CH_SETTLE && en_i) cnt_q <= cnt_q + 1'b1;
            else                           cnt_q <= '0;
        end
    end

    assign out_o     = out_q;
    assign flag_o    = flag_q;
    assign settled_o = (st_q == CH_READY);

    assert_dis_out_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_OFF) |-> out_q);

    assert_change_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q != $past(out_q)) |-> flag_q);

    assert_flag_clear_sw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(clr_i));

    assert_clr_loses_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && chg) |=> flag_q);

    assert_settle_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_READY && $past(st_q) == CH_SETTLE) |-> ($past(cnt_q) == CNT_LAST));
endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
    import cmp_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           wdata_i,
    output logic [DATA_W-1:0]           rdata_o,
    input  logic [NUM_CH-1:0]           flag_i,
    input  logic [NUM_CH-1:0]           out_i,
    input  logic [NUM_CH-1:0]           settled_i,
    output ctrl_t [NUM_CH-1:0]          ctrl_o,
    output logic [NUM_CH-1:0]           clr_o
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CH);

    ctrl_t [NUM_CH-1:0] ctrl_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ctrl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ctrl_q[c] <= '0;
            else if (wr_i && addr_i == ADDR_W'(c)) ctrl_q[c] <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        end
        assign clr_o[c] = wr_i && (addr_i == STAT_ADDR) && wdata_i[c];
    end

    always_comb begin
        rdata_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr_i == ADDR_W'(c)) rdata_o = DATA_W'(ctrl_q[c]);
        end
        if (addr_i == STAT_ADDR) rdata_o = DATA_W'({settled_i, out_i, flag_i});
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/cmp_ctrl_top.sv
module cmp_ctrl_top
    import cmp_pkg::*;
#(
    parameter int NUM_CH        = 2,
    parameter int SETTLE_CYCLES = 500,
    localparam int ADDR_W       = $clog2(NUM_CH + 1),
    localparam int DATA_W       = (3 * NUM_CH > CTRL_W) ? 3 * NUM_CH : CTRL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_CH-1:0]     cmp_raw,
    output logic [NUM_CH-1:0]     ana_en,
    output logic [NUM_CH-1:0]     pos_sel,
    output logic [NUM_CH-1:0]     neg_sel,
    output logic [2*NUM_CH-1:0]   gain_sel,
    output logic [NUM_CH-1:0]     cmp_out,
    output logic [NUM_CH-1:0]     cmp_flag,
    output logic [NUM_CH-1:0]     cmp_irq,
    output logic [NUM_CH-1:0]     cmp_settled
);
    ctrl_t [NUM_CH-1:0] ctrl;
    logic  [NUM_CH-1:0] clr;

    cmp_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .rdata_o  (reg_rdata),
        .flag_i   (cmp_flag),
        .out_i    (cmp_out),
        .settled_i(cmp_settled),
        .ctrl_o   (ctrl),
        .clr_o    (clr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cmp_chan #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (cmp_raw[c]),
            .en_i     (ctrl[c].en),
            .clr_i    (clr[c]),
            .out_o    (cmp_out[c]),
            .flag_o   (cmp_flag[c]),
            .settled_o(cmp_settled[c])
        );
        assign ana_en[c]            = ctrl[c].en;
        assign pos_sel[c]           = ctrl[c].pos;
        assign neg_sel[c]           = ctrl[c].neg;
        assign gain_sel[2*c +: 2]   = ctrl[c].gain;
        assign cmp_irq[c]           = cmp_flag[c] & ctrl[c].ie;
    end
endmodule

// File: tb/cmp_ctrl_top_tb.sv
module cmp_ctrl_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int S = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [5:0] reg_wdata = '0;
    logic [5:0] reg_rdata;
    logic [1:0] cmp_raw = 2'b00;
    logic [1:0] ana_en, pos_sel, neg_sel, cmp_out, cmp_flag, cmp_irq, cmp_settled;
    logic [3:0] gain_sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_ctrl_top #(.NUM_CH(2), .SETTLE_CYCLES(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_raw(cmp_raw),
        .ana_en(ana_en), .pos_sel(pos_sel), .neg_sel(neg_sel), .gain_sel(gain_sel),
        .cmp_out(cmp_out), .cmp_flag(cmp_flag), .cmp_irq(cmp_irq),
        .cmp_settled(cmp_settled)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [5:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [5:0] d;
        rd(2'd0, d); check("R10 ctrl0", d, 0);
        rd(2'd2, d); check("R10 status", d, 6'b001100);
        check("R10 out", cmp_out, 2'b11);
        check("R10 gain", gain_sel, 0);
        check("R10 irq", cmp_irq, 0);
        check("R10 en", ana_en, 0);
    endtask

    task automatic t_compare;
        cmp_raw[0] = 1'b1; tick(3);
        wr(2'd0, 6'h01); tick(1);
        check("R1 enabled high", cmp_out[0], 1);
        check("R3 no change no flag", cmp_flag[0], 0);
        cmp_raw[0] = 1'b0; tick(2);
        check("R1 sync delay", cmp_out[0], 1);
        tick(1);
        check("R1 follows low", cmp_out[0], 0);
        check("R3 flag on fall", cmp_flag[0], 1);
        cmp_raw[0] = 1'b1; tick(3);
        check("R1 follows high", cmp_out[0], 1);
        check("R3 sticky", cmp_flag[0], 1);
    endtask

    task automatic t_clear;
        logic [5:0] d;
        wr(2'd2, 6'h00);
        check("R5 zero write keeps", cmp_flag[0], 1);
        wr(2'd0, 6'h01);
        check("R5 ctrl write keeps", cmp_flag[0], 1);
        wr(2'd2, 6'h01);
        check("R5 cleared", cmp_flag[0], 0);
        rd(2'd2, d); check("R5 status flag0", d[0], 0);
    endtask

    task automatic t_priority;
        cmp_raw[0] = 1'b0; tick(3);
        check("R6 setup flag", cmp_flag[0], 1);
        cmp_raw[0] = 1'b1; tick(2);
        wr(2'd2, 6'h01);
        check("R6 change wins", cmp_flag[0], 1);
        check("R6 out", cmp_out[0], 1);
        wr(2'd2, 6'h01);
        check("R6 plain clear", cmp_flag[0], 0);
    endtask

    task automatic t_irq;
        cmp_raw[0] = 1'b0; tick(3);
        check("R7 flag", cmp_flag[0], 1);
        check("R7 ie off", cmp_irq[0], 0);
        wr(2'd0, 6'h09);
        check("R7 stale fires", cmp_irq[0], 1);
        wr(2'd2, 6'h01);
        check("R7 cleared", cmp_irq[0], 0);
    endtask

    task automatic t_disable;
        check("R4 pre low", cmp_out[0], 0);
        wr(2'd0, 6'h00); tick(1);
        check("R4 forced high", cmp_out[0], 1);
        check("R4 flag on disable", cmp_flag[0], 1);
        check("R4 ana_en off", ana_en[0], 0);
        cmp_raw[0] = 1'b1; tick(3); cmp_raw[0] = 1'b0; tick(3);
        check("R4 raw ignored", cmp_out[0], 1);
        wr(2'd2, 6'h01);
        check("R4 clear after", cmp_flag[0], 0);
    endtask

    task automatic t_select;
        wr(2'd0, 6'b000110);
        check("R2 pos0", pos_sel[0], 1);
        check("R2 neg0", neg_sel[0], 1);
        check("R2 ch1 untouched", {pos_sel[1], neg_sel[1]}, 0);
        check("R2 en0", ana_en[0], 0);
    endtask

    task automatic t_gain;
        logic [5:0] d;
        wr(2'd0, 6'h10); wr(2'd1, 6'h20);
        check("R9 4x/8x", gain_sel, 4'b1001);
        wr(2'd1, 6'h30);
        check("R9 16x", gain_sel, 4'b1101);
        rd(2'd1, d); check("R9 readback", d, 6'h30);
        wr(2'd1, 6'h00);
        check("R9 2x", gain_sel[3:2], 0);
    endtask

    task automatic t_settle;
        logic [5:0] d;
        cmp_raw[1] = 1'b1; tick(3);
        check("R8 off", cmp_settled[1], 0);
        wr(2'd1, 6'h01);
        tick(S);
        check("R8 still settling", cmp_settled[1], 0);
        tick(1);
        check("R8 settled", cmp_settled[1], 1);
        rd(2'd2, d); check("R8 status bit", d[5], 1);
        check("R8 out no flag", {cmp_out[1], cmp_flag[1]}, 2'b10);
        wr(2'd1, 6'h00); tick(1);
        check("R8 disable clears", cmp_settled[1], 0);
        wr(2'd1, 6'h01); tick(10);
        wr(2'd1, 6'h00);
        wr(2'd1, 6'h01);
        tick(S);
        check("R8 restart", cmp_settled[1], 0);
        tick(1);
        check("R8 restart done", cmp_settled[1], 1);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_compare();
        t_clear();
        t_priority();
        t_irq();
        t_disable();
        t_select();
        t_gain();
        t_settle();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog act=running exp=done");
            summary();
        end
    end
endmodule